// File: doc/BRIEF.md
# Slave-Serial Configuration Loader

This block runs the pin-level handshake that loads a serially configured programmable device. It drives an active-low program line, a configuration clock and a serial data line. It watches the device's init and done lines. After a start pulse it resets the device and waits for init to fall. It then releases the program line and waits for init to rise again. Next it clocks in bits from an upstream source, and finally it waits for done.

Each of the three waits has its own timeout and its own failure code. Time is measured in polls produced by a prescaler on the system clock, nominally one per millisecond. Serial bits come in over a valid/ready handshake, one bit per transfer, and the last bit carries a marker. Each bit becomes a four-step clock/data waveform. The serial data line sits high between bits.

Top module: `cfg_loader`

## Requirements
- R1: After reset, and whenever no load is running, the program line, configuration clock and serial data outputs are all high, `busy_o` is low and `bit_ready_o` is low. Out of reset `pass_o` and `fail_o` are low.
- R2: A start pulse while not busy pulls the program line low at the next clock edge, keeps clock and data high, raises `busy_o`, and clears `pass_o`, `fail_o` and `fail_code_o`.
- R3: If the synchronized init input has not gone low after MAX_POLLS polls (MAX_POLLS*TICK_DIV clocks from the start edge), the load fails with `fail_code_o` = 1. All device outputs then return high.
- R4: Once init is seen low, the program line goes high. If init does not return high within MAX_POLLS polls, the load fails with `fail_code_o` = 2.
- R5: Each bit is sent in four steps of STEP_CYC clocks each: clock low/data high, clock low/data = bit, clock high/data = bit, clock high/data high. Bits go out in transfer order. The clock therefore stays low for 2*STEP_CYC clocks per bit, and data is the bit value when the clock rises.
- R6: `bit_ready_o` is high only during the bit phase while no bit is being sent. `bit_valid_i` has no effect at any other time: no clock edge is produced.
- R7: After the bit marked last is sent, the block waits for done. Done seen high gives `pass_o` = 1. Otherwise, after MAX_POLLS polls, it fails with `fail_code_o` = 3 (code 0 means no failure).
- R8: `busy_o`, `pass_o`, `fail_o` and `fail_code_o` hold their values until the next accepted start. A start pulse while busy is ignored.
- R9: The init and done inputs pass through a two-flop synchronizer. If a wait condition and the final timeout poll land in the same cycle, the condition wins. A condition that lands one cycle later loses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| bit_valid_i | input | 1 | Upstream bit valid |
| bit_data_i | input | 1 | Upstream bit value |
| bit_last_i | input | 1 | Marks the final bit |
| bit_ready_o | output | 1 | Block accepts a bit |
| dev_prog_n_o | output | 1 | Active-low program line to device |
| dev_cclk_o | output | 1 | Configuration clock to device |
| dev_din_o | output | 1 | Serial data to device |
| dev_init_i | input | 1 | Device init status (asynchronous) |
| dev_done_i | input | 1 | Device done status (asynchronous) |
| busy_o | output | 1 | Load in progress |
| pass_o | output | 1 | Load completed successfully |
| fail_o | output | 1 | Load failed |
| fail_code_o | output | 2 | 1 init stuck high, 2 init stuck low, 3 no done, 0 none |

## Verification
The sensitive collision is a wait condition arriving in the same cycle as the final timeout poll. The bench counts clocks from the start edge and drops init so that its synchronized value lands exactly on the last poll edge. It expects the program line to be released with no failure. It then repeats the run with the drop one clock later and expects failure code 1. The bit waveform is judged by a scoreboard. The scoreboard compares the data at each configuration clock rise against the queued bits and measures the low time of the clock.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_INIT_WAIT,
    ST_SHIFT,
    ST_DONE_WAIT,
    ST_END
  } seq_state_e;

  typedef enum logic [1:0] {
    FC_NONE          = 2'd0,
    FC_INIT_STUCK_HI = 2'd1,
    FC_INIT_STUCK_LO = 2'd2,
    FC_NO_DONE       = 2'd3
  } fail_code_e;
endpackage

// File: rtl/cfg_tick_gen.sv
module cfg_tick_gen #(
  parameter int unsigned DIV = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned W       = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[gi] <= RST_VAL;
        sync_q[gi] <= RST_VAL;
      end else begin
        meta_q[gi] <= d_i[gi];
        sync_q[gi] <= meta_q[gi];
      end
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/cfg_bit_shaper.sv
module cfg_bit_shaper #(
  parameter int unsigned STEP_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic bit_i,
  output logic active_o,
  output logic fin_o,
  output logic sclk_o,
  output logic sdata_o
);
  localparam int unsigned SW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [SW-1:0] CYC_LAST = SW'(STEP_CYC - 1);

  logic          active_q;
  logic [1:0]    step_q;
  logic [SW-1:0] cyc_q;
  logic          bit_q;
  logic          step_end;

  assign step_end = (cyc_q == CYC_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      step_q   <= '0;
      cyc_q    <= '0;
      bit_q    <= 1'b1;
    end else if (!active_q) begin
      if (load_i) begin
        active_q <= 1'b1;
        step_q   <= '0;
        cyc_q    <= '0;
        bit_q    <= bit_i;
      end
    end else if (step_end) begin
      cyc_q <= '0;
      if (step_q == 2'd3) active_q <= 1'b0;
      else                step_q   <= step_q + 1'b1;
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  // step 0: clk lo/data hi, 1: clk lo/bit, 2: clk hi/bit, 3: clk hi/data hi
  always_comb begin
    sclk_o  = 1'b1;
    sdata_o = 1'b1;
    if (active_q) begin
      unique case (step_q)
        2'd0: sclk_o = 1'b0;
        2'd1: begin sclk_o = 1'b0; sdata_o = bit_q; end
        2'd2: sdata_o = bit_q;
        default: ;
      endcase
    end
  end

  assign active_o = active_q;
  assign fin_o    = active_q && (step_q == 2'd3) && step_end;
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned TICK_DIV  = 50000,
  parameter int unsigned STEP_CYC  = 4,
  parameter int unsigned MAX_POLLS = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       bit_valid_i,
  input  logic       bit_data_i,
  input  logic       bit_last_i,
  output logic       bit_ready_o,
  output logic       dev_prog_n_o,
  output logic       dev_cclk_o,
  output logic       dev_din_o,
  input  logic       dev_init_i,
  input  logic       dev_done_i,
  output logic       busy_o,
  output logic       pass_o,
  output logic       fail_o,
  output logic [1:0] fail_code_o
);
  localparam int unsigned PW = $clog2(MAX_POLLS + 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS - 1);

  seq_state_e    state_q, state_d;
  logic [PW-1:0] poll_q;
  logic          tick, timeout, tick_clr;
  logic [1:0]    sync_q;
  logic          init_s, done_s;
  logic          sh_active, sh_fin, sh_clk, sh_data;
  logic          accept, last_q;
  logic          launch, set_pass, set_fail;
  fail_code_e    code_d, code_q;
  logic          pass_q, fail_q;

  cfg_sync #(.W(2), .RST_VAL(1'b0)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dev_done_i, dev_init_i}),
    .q_o   (sync_q)
  );
  assign init_s = sync_q[0];
  assign done_s = sync_q[1];

  // prescaler restarts on every phase change so each wait gets full polls
  assign tick_clr = (state_d != state_q);

  cfg_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tick_clr),
    .tick_o(tick)
  );

  assign bit_ready_o = (state_q == ST_SHIFT) && !sh_active;
  assign accept      = bit_valid_i && bit_ready_o;

  cfg_bit_shaper #(.STEP_CYC(STEP_CYC)) u_shaper (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .bit_i   (bit_data_i),
    .active_o(sh_active),
    .fin_o   (sh_fin),
    .sclk_o  (sh_clk),
    .sdata_o (sh_data)
  );

  assign timeout = tick && (poll_q == POLL_LAST);

  always_comb begin
    state_d  = state_q;
    launch   = 1'b0;
    set_pass = 1'b0;
    set_fail = 1'b0;
    code_d   = FC_NONE;
    unique case (state_q)
      ST_IDLE, ST_END: begin
        if (start_i) begin
          state_d = ST_PROG;
          launch  = 1'b1;
        end
      end
      ST_PROG: begin
        if (!init_s) state_d = ST_INIT_WAIT;
        else if (timeout) begin
          state_d  = ST_END;
          set_fail = 1'b1;
          code_d   = FC_INIT_STUCK_HI;
        end
      end
      ST_INIT_WAIT: begin
        if (init_s) state_d = ST_SHIFT;
        else if (timeout) begin
          state_d  = ST_END;
          set_fail = 1'b1;
          code_d   = FC_INIT_STUCK_LO;
        end
      end
      ST_SHIFT: begin
        if (sh_fin && last_q) state_d = ST_DONE_WAIT;
      end
      ST_DONE_WAIT: begin
        if (done_s) begin
          state_d  = ST_END;
          set_pass = 1'b1;
        end else if (timeout) begin
          state_d  = ST_END;
          set_fail = 1'b1;
          code_d   = FC_NO_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      poll_q  <= '0;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (tick_clr)  poll_q <= '0;
      else if (tick) poll_q <= poll_q + 1'b1;
      if (launch)      last_q <= 1'b0;
      else if (accept) last_q <= bit_last_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      code_q <= FC_NONE;
    end else if (launch) begin
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      code_q <= FC_NONE;
    end else if (set_pass) begin
      pass_q <= 1'b1;
    end else if (set_fail) begin
      fail_q <= 1'b1;
      code_q <= code_d;
    end
  end

  assign dev_prog_n_o = (state_q != ST_PROG);
  assign dev_cclk_o   = sh_clk;
  assign dev_din_o    = sh_data;
  assign busy_o       = (state_q == ST_PROG) || (state_q == ST_INIT_WAIT) ||
                        (state_q == ST_SHIFT) || (state_q == ST_DONE_WAIT);
  assign pass_o       = pass_q;
  assign fail_o       = fail_q;
  assign fail_code_o  = code_q;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       bit_ready_o,
  input logic       dev_prog_n_o,
  input logic       dev_cclk_o,
  input logic       dev_din_o,
  input logic       busy_o,
  input logic       pass_o,
  input logic       fail_o,
  input logic [1:0] fail_code_o
);
  a_r1_idle_pins_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (dev_prog_n_o && dev_cclk_o && dev_din_o && !bit_ready_o));

  a_r2_start_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (!dev_prog_n_o && busy_o && !pass_o && !fail_o));

  a_r5_data_stable_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dev_cclk_o) |-> $stable(dev_din_o));

  a_r5_data_high_at_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dev_cclk_o) |-> dev_din_o);

  a_r6_ready_in_bit_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_ready_o |-> (busy_o && dev_prog_n_o));

  a_r7_pass_fail_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o));

  a_r7_fail_has_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (fail_code_o != 2'd0));

  a_r8_status_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(pass_o) && $stable(fail_o) && $stable(fail_code_o)));
endmodule

bind cfg_loader cfg_loader_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .bit_ready_o (bit_ready_o),
  .dev_prog_n_o(dev_prog_n_o),
  .dev_cclk_o  (dev_cclk_o),
  .dev_din_o   (dev_din_o),
  .busy_o      (busy_o),
  .pass_o      (pass_o),
  .fail_o      (fail_o),
  .fail_code_o (fail_code_o)
);

// File: tb/sim_cfg_loader.sv
module sim_cfg_loader;
  localparam int unsigned TD = 8;
  localparam int unsigned SC = 2;
  localparam int unsigned MP = 5;
  localparam int unsigned TO = TD * MP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, bvalid = 1'b0, bdata = 1'b0, blast = 1'b0;
  logic init_in = 1'b1, done_in = 1'b0;
  logic bready, prog_n, cclk, din, busy, pass, fail;
  logic [1:0] code;

  int n_cmp = 0;
  int n_bad = 0;
  bit exp_q[$];
  bit prev_clk = 1'b1;
  int low_cnt = 0;

  always #10 clk = ~clk;

  cfg_loader #(.TICK_DIV(TD), .STEP_CYC(SC), .MAX_POLLS(MP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .bit_valid_i(bvalid), .bit_data_i(bdata), .bit_last_i(blast),
    .bit_ready_o(bready), .dev_prog_n_o(prog_n), .dev_cclk_o(cclk),
    .dev_din_o(din), .dev_init_i(init_in), .dev_done_i(done_in),
    .busy_o(busy), .pass_o(pass), .fail_o(fail), .fail_code_o(code)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // driver: hand one bit over, push its expected value on acceptance
  task automatic send_bit(bit b, bit last);
    @(negedge clk);
    bvalid = 1'b1; bdata = b; blast = last;
    for (int i = 0; i < 200 && !bready; i++) @(negedge clk);
    @(negedge clk);
    exp_q.push_back(b);
    bvalid = 1'b0; blast = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_prog_high();
    for (int i = 0; i < 60 && !prog_n; i++) @(negedge clk);
  endtask

  task automatic reach_bit_phase();
    pulse_start();
    repeat (2) @(negedge clk);
    init_in = 1'b0;
    wait_prog_high();
    chk("R4", "program released after init low", prog_n, 1);
    repeat (2) @(negedge clk);
    init_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // monitor: score each configuration clock rise against the queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cclk) low_cnt++;
      else begin
        if (!prev_clk) begin
          if (exp_q.size() == 0) chk("R6", "clock rise with no bit queued", 1, 0);
          else begin
            chk("R5", "bit value at clock rise", din, exp_q.pop_front());
            chk("R5", "clock low cycles", low_cnt, 2 * SC);
          end
        end
        low_cnt = 0;
      end
      prev_clk = cclk;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    bit pattern[9] = '{1, 0, 1, 1, 0, 0, 1, 0, 1};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "prog_n", prog_n, 1);
    chk("R1", "cclk", cclk, 1);
    chk("R1", "din", din, 1);
    chk("R1", "busy", busy, 0);
    chk("R1", "ready", bready, 0);
    chk("R1", "pass|fail", pass | fail, 0);

    // R6 valid while idle has no effect
    bvalid = 1'b1; bdata = 1'b0;
    repeat (5) @(negedge clk);
    chk("R6", "ready while idle", bready, 0);
    chk("R6", "cclk while idle", cclk, 1);
    bvalid = 1'b0;

    // normal load
    pulse_start();
    chk("R2", "prog_n after start", prog_n, 0);
    chk("R2", "cclk after start", cclk, 1);
    chk("R2", "din after start", din, 1);
    chk("R2", "busy after start", busy, 1);
    repeat (3) @(negedge clk);
    chk("R6", "ready during reset phase", bready, 0);
    init_in = 1'b0;
    wait_prog_high();
    chk("R4", "program released", prog_n, 1);
    repeat (2) @(negedge clk);
    init_in = 1'b1;
    foreach (pattern[k]) send_bit(pattern[k], k == 8);
    repeat (4 * SC + 4) @(negedge clk);
    chk("R7", "busy while waiting done", busy, 1);
    chk("R7", "no pass before done", pass, 0);
    pulse_start();
    chk("R8", "start ignored while busy: prog_n", prog_n, 1);
    chk("R8", "start ignored while busy: busy", busy, 1);
    done_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7", "pass", pass, 1);
    chk("R7", "fail", fail, 0);
    chk("R7", "code", code, 0);
    chk("R7", "busy cleared", busy, 0);
    chk("R5", "all bits clocked", exp_q.size(), 0);
    repeat (10) @(negedge clk);
    chk("R8", "pass held", pass, 1);
    chk("R1", "pins high after end", {prog_n, cclk, din}, 7);

    // init never falls -> code 1
    done_in = 1'b0;
    pulse_start();
    chk("R8", "pass cleared by start", pass, 0);
    repeat (TO + 2) @(negedge clk);
    chk("R3", "fail", fail, 1);
    chk("R3", "code", code, 1);
    chk("R3", "prog_n released", prog_n, 1);
    chk("R3", "busy", busy, 0);

    // R9 init lands exactly on the last poll: condition wins
    pulse_start();
    repeat (TO - 3) @(negedge clk);
    init_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "on-time init: fail", fail, 0);
    chk("R9", "on-time init: prog released", prog_n, 1);
    chk("R9", "on-time init: busy", busy, 1);
    repeat (TO + 2) @(negedge clk);
    chk("R4", "init stuck low: fail", fail, 1);
    chk("R4", "init stuck low: code", code, 2);
    init_in = 1'b1;
    repeat (3) @(negedge clk);

    // R9 one cycle late: timeout wins
    pulse_start();
    repeat (TO - 2) @(negedge clk);
    init_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "late init: fail", fail, 1);
    chk("R9", "late init: code", code, 1);
    init_in = 1'b1;
    repeat (3) @(negedge clk);

    // done never rises -> code 3
    reach_bit_phase();
    send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b1);
    repeat (4 * SC + 2 + TO + 4) @(negedge clk);
    chk("R7", "no done: fail", fail, 1);
    chk("R7", "no done: code", code, 3);
    chk("R7", "no done: pass", pass, 0);
    repeat (5) @(negedge clk);
    chk("R8", "fail code held", code, 3);
    chk("R5", "all bits clocked", exp_q.size(), 0);

    finish_run();
  end
endmodule